// File: doc/BRIEF.md
# Variable-Length Bitstream Packer

The packer sits behind a compressing encoder and joins its variable-length codes into one gap-free bitstream. Each code word and its bit count arrive through two companion queues. The codes are popped as pairs and their valid bits are appended to an accumulator. Every time 32 bits have built up, the packer pushes one full word into an output queue that a processor drains. Bits beyond the word boundary stay behind and begin the next word. A single code may be wider than the output word: an encoder with 11 remainder bits can emit up to 43 bits. Such a code yields one or two words on back-to-back cycles.

All three queues are seen as synchronous first-word-fall-through interfaces in the fast clock domain:
- An input entry is valid while its empty flag is low, and a pop consumes it.
- A push into the output queue is made only while that queue is not full.

A flush pulse closes the stream. Intake stops, every held bit is pushed out, and the last partial word is padded with zeros.

Top module: `bitpack_top`

## Requirements
- R1: After reset the accumulator is empty, and neither pop nor push is asserted until queue entries arrive.
- R2: Code bits enter the stream LSB first. Bit 0 of the first code after reset or after a completed flush lands in bit 0 of an output word. Each later code starts at the bit position equal to the sum of the earlier lengths, modulo 32.
- R3: A word is pushed once at least 32 bits are held. The held bits above the pushed 32 move down and begin the next word.
- R4: Bits of the code entry at positions equal to or above its length value are ignored. They never appear in the stream.
- R5: Lengths from 0 to 64 are accepted, and a length of 0 consumes the pair without adding bits. A code that overfills the word yields one or two words on consecutive cycles while the output queue is not full.
- R6: Both queues are popped together, in the same cycle. A pop happens only when both are non-empty, fewer than 32 bits are held and no flush is in progress.
- R7: A push happens only while the output queue is not full. While it is full, the pending word is held unchanged and no bit is lost.
- R8: A flush pulse blocks further pops until all held bits are pushed. The final partial word has zeros above its valid bits. A flush with an empty accumulator pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| code_data | input | 64 | Head entry of the code queue; bits above the length are don't-care |
| code_empty | input | 1 | Code queue has no entry |
| code_pop | output | 1 | Consume the head of the code queue |
| len_data | input | 7 | Head entry of the length queue, valid bit count 0 to 64 |
| len_empty | input | 1 | Length queue has no entry |
| len_pop | output | 1 | Consume the head of the length queue |
| out_data | output | 32 | Word offered to the output queue |
| out_push | output | 1 | Write out_data into the output queue |
| out_full | input | 1 | Output queue cannot take a word |
| flush | input | 1 | One-cycle request to drain all held bits |

## Verification
Several rules are checked on every cycle:
- Pops happen only under the permitted conditions, and never during a flush.
- No push is made into a full queue.
- A pending word stays stable while the queue is full.
- The valid-bit count stays within the accumulator.
- Any partial word has zero padding above its valid bits.

Whether the bits arrive in the right order and at the right positions is shown only by the bench scenarios. The bench compares every pushed word against a bit-level model of the concatenated stream. The scenarios cover fixed 12-bit codes, random lengths with junk upper bits and random back-pressure, 43- and 64-bit codes that straddle word boundaries, one queue empty while the other holds data, and flushes with and without held bits.

// File: rtl/bitpack_pkg.sv
package bitpack_pkg;
  parameter int unsigned DEF_OUT_W  = 32;
  parameter int unsigned DEF_CODE_W = 64;

  // The accumulator must absorb a maximal code on top of a not-quite-full word.
  function automatic int unsigned acc_width(input int unsigned out_w, input int unsigned code_w);
    return out_w + code_w;
  endfunction
endpackage

// File: rtl/bitpack_mask.sv
module bitpack_mask #(
  parameter int unsigned CODE_W = 64,
  parameter int unsigned LEN_W  = 7
) (
  input  logic [CODE_W-1:0] code_in,
  input  logic [LEN_W-1:0]  len_in,
  output logic [CODE_W-1:0] code_clean
);
  // Keep only bits below the stated length.
  for (genvar i = 0; i < CODE_W; i++) begin : g_bit
    assign code_clean[i] = code_in[i] & (len_in > LEN_W'(i));
  end
endmodule

// File: rtl/bitpack_ctrl.sv
module bitpack_ctrl #(
  parameter int unsigned OUT_W = 32,
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             code_empty,
  input  logic             len_empty,
  input  logic             out_full,
  input  logic             flush,
  input  logic [CNT_W-1:0] fill,
  output logic             take,
  output logic             emit,
  output logic             drain_q
);
  localparam logic [CNT_W-1:0] WORD_BITS = CNT_W'(OUT_W);

  logic have_word;
  logic have_any;

  assign have_word = (fill >= WORD_BITS);
  assign have_any  = (fill != '0);

  assign emit = !out_full && (have_word || (drain_q && have_any));
  assign take = !code_empty && !len_empty && !have_word && !flush && !drain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drain_q <= 1'b0;
    end else if (flush) begin
      drain_q <= 1'b1;
    end else if (drain_q && !have_any) begin
      drain_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bitpack_accum.sv
module bitpack_accum #(
  parameter int unsigned OUT_W  = 32,
  parameter int unsigned CODE_W = 64,
  parameter int unsigned LEN_W  = 7,
  parameter int unsigned ACC_W  = 96,
  parameter int unsigned CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              emit,
  input  logic [CODE_W-1:0] code_clean,
  input  logic [LEN_W-1:0]  len_in,
  output logic [OUT_W-1:0]  word,
  output logic [CNT_W-1:0]  fill
);
  localparam logic [CNT_W-1:0] WORD_BITS = CNT_W'(OUT_W);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] placed;

  assign placed = ACC_W'(code_clean) << fill;
  assign word   = acc_q[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      fill  <= '0;
    end else if (emit) begin
      acc_q <= acc_q >> OUT_W;
      fill  <= (fill >= WORD_BITS) ? (fill - WORD_BITS) : '0;
    end else if (take) begin
      acc_q <= acc_q | placed;
      fill  <= fill + CNT_W'(len_in);
    end
  end
endmodule

// File: rtl/bitpack_top.sv
module bitpack_top
  import bitpack_pkg::*;
#(
  parameter int unsigned OUT_W  = DEF_OUT_W,
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned LEN_W  = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_data,
  input  logic              code_empty,
  output logic              code_pop,
  input  logic [LEN_W-1:0]  len_data,
  input  logic              len_empty,
  output logic              len_pop,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_push,
  input  logic              out_full,
  input  logic              flush
);
  localparam int unsigned ACC_W = acc_width(OUT_W, CODE_W);
  localparam int unsigned CNT_W = $clog2(ACC_W + 1);

  logic [CODE_W-1:0] code_clean;
  logic [CNT_W-1:0]  fill;
  logic              take;
  logic              emit;
  logic              drain_q;

  bitpack_mask #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_mask (
    .code_in    (code_data),
    .len_in     (len_data),
    .code_clean (code_clean)
  );

  bitpack_ctrl #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .code_empty (code_empty),
    .len_empty  (len_empty),
    .out_full   (out_full),
    .flush      (flush),
    .fill       (fill),
    .take       (take),
    .emit       (emit),
    .drain_q    (drain_q)
  );

  bitpack_accum #(
    .OUT_W(OUT_W), .CODE_W(CODE_W), .LEN_W(LEN_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
  ) u_accum (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .emit       (emit),
    .code_clean (code_clean),
    .len_in     (len_data),
    .word       (out_data),
    .fill       (fill)
  );

  assign code_pop = take;
  assign len_pop  = take;
  assign out_push = emit;
endmodule

// File: rtl/bitpack_chk.sv
module bitpack_chk #(
  parameter int unsigned OUT_W = 32,
  parameter int unsigned ACC_W = 96,
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             code_empty,
  input logic             len_empty,
  input logic             code_pop,
  input logic             len_pop,
  input logic [OUT_W-1:0] out_data,
  input logic             out_push,
  input logic             out_full,
  input logic             drain_q,
  input logic [CNT_W-1:0] fill
);
  localparam logic [CNT_W-1:0] WORD_BITS = CNT_W'(OUT_W);
  localparam logic [CNT_W-1:0] MAX_FILL  = CNT_W'(ACC_W - 1);

  p_pop_cond_r6: assert property (@(posedge clk) disable iff (rst)
    (code_pop || len_pop) |-> (code_pop && len_pop && !code_empty && !len_empty && fill < WORD_BITS));

  p_no_push_full_r7: assert property (@(posedge clk) disable iff (rst)
    out_push |-> !out_full);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_full && fill >= WORD_BITS) |=> $stable(out_data));

  p_flush_no_pop_r8: assert property (@(posedge clk) disable iff (rst)
    drain_q |-> !code_pop);

  p_pad_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (out_push && fill < WORD_BITS) |-> ((out_data >> fill) == '0));

  p_fill_bound_r5: assert property (@(posedge clk) disable iff (rst)
    fill <= MAX_FILL);
endmodule

bind bitpack_top bitpack_chk #(.OUT_W(OUT_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .code_empty (code_empty),
  .len_empty  (len_empty),
  .code_pop   (code_pop),
  .len_pop    (len_pop),
  .out_data   (out_data),
  .out_push   (out_push),
  .out_full   (out_full),
  .drain_q    (drain_q),
  .fill       (fill)
);

// File: tb/sim_bitpack_top.sv
`timescale 1ns/1ps
module sim_bitpack_top;
  localparam int OW = 32;
  localparam int CW = 64;
  localparam int LW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] code_data;
  logic          code_empty;
  logic          code_pop;
  logic [LW-1:0] len_data;
  logic          len_empty;
  logic          len_pop;
  logic [OW-1:0] out_data;
  logic          out_push;
  logic          out_full = 1'b0;
  logic          flush = 1'b0;

  always #5 clk = ~clk;

  logic [CW-1:0] cq [0:1023];
  logic [LW-1:0] lq [0:1023];
  int cwr = 0, lwr = 0, rd = 0;
  logic [OW-1:0] got [0:2047];
  int got_n = 0;
  logic exp_bits [0:32767];
  int nbits = 0;
  int phase_base = 0;
  int total = 0, bad = 0;

  assign code_data  = cq[rd[9:0]];
  assign len_data   = lq[rd[9:0]];
  assign code_empty = (rd >= cwr);
  assign len_empty  = (rd >= lwr);

  bitpack_top u0 (
    .clk(clk), .rst(rst),
    .code_data(code_data), .code_empty(code_empty), .code_pop(code_pop),
    .len_data(len_data), .len_empty(len_empty), .len_pop(len_pop),
    .out_data(out_data), .out_push(out_push), .out_full(out_full),
    .flush(flush)
  );

  always @(posedge clk) begin
    if (code_pop) rd <= rd + 1;
    if (out_push) begin
      got[got_n[10:0]] <= out_data;
      got_n <= got_n + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] exp_word(input int k);
    logic [OW-1:0] w = '0;
    for (int b = 0; b < OW; b++)
      if (k * OW + b < nbits) w[b] = exp_bits[k * OW + b];
    return w;
  endfunction

  task automatic put_code(input logic [CW-1:0] c);
    cq[cwr[9:0]] = c;
    cwr++;
  endtask

  task automatic put_len(input int len, input logic [CW-1:0] c);
    lq[lwr[9:0]] = LW'(len);
    lwr++;
    for (int i = 0; i < len; i++) exp_bits[nbits + i] = c[i];
    nbits += len;
  endtask

  task automatic enq(input logic [CW-1:0] c, input int len);
    put_code(c);
    put_len(len, c);
  endtask

  task automatic start_phase();
    nbits = 0;
    phase_base = got_n;
  endtask

  task automatic drain(input bit rand_full);
    while (rd != cwr) begin
      @(negedge clk);
      out_full = rand_full ? (($urandom % 3) == 0) : 1'b0;
    end
  endtask

  task automatic do_flush(input bit rand_full);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    repeat (20) begin
      @(negedge clk);
      out_full = rand_full ? (($urandom % 3) == 0) : 1'b0;
    end
    out_full = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic phase_check(input string req);
    int nw;
    nw = (nbits + OW - 1) / OW;
    check({req, " word count"}, 64'(got_n - phase_base), 64'(nw));
    for (int k = 0; k < nw; k++)
      check(req, 64'(got[(phase_base + k) % 2048]), 64'(exp_word(k)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seen;
    void'($urandom(32'h1a2b3c4d));
    for (int i = 0; i < 1024; i++) begin cq[i] = '0; lq[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    check("R1 push after reset", 64'(out_push), 64'd0);
    check("R1 pop after reset", 64'(code_pop), 64'd0);

    // R1 R2 R3: eight 12-bit codes fill exactly three words; flush then adds nothing (R8)
    start_phase();
    for (int i = 0; i < 8; i++) enq(64'hABC0 + 64'(i * 16'h111), 12);
    drain(1'b0);
    repeat (4) @(negedge clk);
    check("R3 words before flush", 64'(got_n - phase_base), 64'd3);
    do_flush(1'b0);
    phase_check("R2 R3 12-bit packing");

    // R4 R5: junk upper bits, long and zero-length codes across boundaries
    start_phase();
    enq({$urandom, $urandom}, 31);
    enq({$urandom, $urandom}, 43);
    enq({$urandom, $urandom}, 0);
    enq({$urandom, $urandom}, 64);
    enq({$urandom, $urandom}, 5);
    drain(1'b0);
    do_flush(1'b0);
    phase_check("R4 R5 long codes");

    // R6: code queue holds data but length queue is empty
    start_phase();
    seen = got_n;
    put_code(64'h0000_0000_0000_0F0F);
    repeat (8) @(negedge clk);
    check("R6 no pop with one queue empty", 64'(rd), 64'(cwr - 1));
    check("R6 no push with one queue empty", 64'(got_n), 64'(seen));
    put_len(16, 64'h0000_0000_0000_0F0F);
    drain(1'b0);
    do_flush(1'b0);
    phase_check("R6 paired pop");

    // R7: output full holds the word and loses nothing
    start_phase();
    out_full = 1'b1;
    seen = got_n;
    for (int i = 0; i < 3; i++) enq(64'h0000_0000_0000_0123 * 64'(i + 1), 12);
    repeat (12) @(negedge clk);
    check("R7 no push while full", 64'(got_n), 64'(seen));
    out_full = 1'b0;
    drain(1'b0);
    do_flush(1'b0);
    phase_check("R7 stall recovery");

    // R8: flush with nothing held pushes nothing
    seen = got_n;
    do_flush(1'b0);
    check("R8 empty flush", 64'(got_n), 64'(seen));

    // R2 R3 R4 R5 R7 R8: random lengths with random back-pressure
    for (int p = 0; p < 3; p++) begin
      start_phase();
      for (int i = 0; i < 100; i++) begin
        int len;
        len = (($urandom % 10) == 0) ? 44 + int'($urandom % 21) : int'($urandom % 44);
        enq({$urandom, $urandom}, len);
      end
      drain(1'b1);
      do_flush(1'b1);
      phase_check("R2 R5 R7 R8 random stream");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule